// File: doc/BRIEF.md
# Energy-Sensing Transceiver Sleep Controller

This block manages power for one or more ports of an Ethernet transceiver. Each port has two ways to power down. A forced power-off holds the transceiver unpowered until software releases it, and release brings it back with a one-cycle reset pulse. An energy-sensing sleep powers the transceiver down after the line has been quiet for a while, and wakes it again when line energy or qualifying link pulses come back. Waking from the sleep keeps the transceiver's prior state: no reset pulse is issued and none of the configuration inputs is touched.

A port can wake on a single received link pulse, or it can require a second pulse within a selectable window. While it sleeps, it can issue a periodic beacon strobe for the pulse generator, at a selectable period. Every wake from sleep sets a sticky per-port interrupt flag. These flags, each gated by a per-port enable, are ORed onto one shared event output.

All the controls are plain level inputs that register fields are expected to drive. The controller keeps no copy of them, so entering or leaving a power-down mode cannot alter them.

Top module: `energy_sleep_ctrl`

## Requirements
- R1: While a port's force_off is 1 at a clock edge, that port's xcvr_pwr_en is 0 after the edge. It stays 0 as long as force_off stays 1, whatever the line energy, received pulses or sleep settings.
- R2: A forced-off port that samples force_off 0 is powered after that edge. Its xcvr_rst is 1 for exactly that first powered cycle and 0 afterwards.
- R3: With sleep_en 1, a powered port enters sleep (xcvr_pwr_en 0, awake 0) at the QUIET_CYC-th consecutive edge (default 4) that samples line_energy 0. An edge with line_energy 1 or sleep_en 0 restarts the count.
- R4: A sleeping port that samples line_energy 1 is powered after that edge, with awake 1 and wake_irq set. xcvr_rst stays 0, so the prior state is kept.
- R5: With sleep_en 0, a port stays powered regardless of line energy. Clearing sleep_en while asleep powers the port at the next edge without setting wake_irq. After reset, every port is powered and all flags are low.
- R6: With one_pulse_wake 1, a single rx_pulse sampled while asleep wakes the port at that edge.
- R7: With one_pulse_wake 0, the first rx_pulse arms a window of WIN cycles, where WIN is 8, 16, 32 or 64 for pair_win_sel values 0 to 3. A second pulse sampled 1 to WIN edges after the first wakes the port. If no second pulse arrives in time, the first is dropped and the next pulse arms a new window.
- R8: While asleep with beacon_en 1, beacon is high for one cycle in every PER cycles, where PER is 16, 32, 64 or 128 for beacon_sel values 0 to 3. The first strobe comes in the PER-th cycle after the beacon starts. Beacon stays 0 while the port is powered or beacon_en is 0.
- R9: wake_irq stays set until an edge samples irq_clr 1. A clear sampled at the same edge as a wake leaves the flag set.
- R10: evt_out is the OR over the ports of wake_irq AND evt_en. The inputs of one port never change the power state or the flag of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_off | input | NPORTS | Per-port forced power-off |
| sleep_en | input | NPORTS | Per-port energy-sensing sleep enable |
| beacon_en | input | NPORTS | Per-port beacon enable during sleep |
| beacon_sel | input | 2*NPORTS | Per-port beacon period select, 2 bits each |
| one_pulse_wake | input | NPORTS | Per-port wake on a single pulse |
| pair_win_sel | input | 2*NPORTS | Per-port two-pulse window select, 2 bits each |
| line_energy | input | NPORTS | Per-port line energy indication |
| rx_pulse | input | NPORTS | Per-port received link pulse strobe |
| irq_clr | input | NPORTS | Per-port wake flag clear strobe |
| evt_en | input | NPORTS | Per-port enable onto the shared event |
| xcvr_pwr_en | output | NPORTS | Transceiver power enable |
| xcvr_rst | output | NPORTS | One-cycle transceiver reset after forced power-off |
| beacon | output | NPORTS | Beacon strobe while sleeping |
| awake | output | NPORTS | Low only while the port is in energy sleep |
| wake_irq | output | NPORTS | Sticky wake flag |
| evt_out | output | 1 | Shared power-management event |

## Verification
A quiet counter that is off by one moves the sleep entry one edge earlier or later. The fixed vector table catches this at the exact edge where xcvr_pwr_en is expected to fall. A window counter that is wrong, or an armed flag that is stuck, shows as a wake one pulse too early or a missed wake at the window boundary, within one cycle of the pulse that decides the case. A beacon counter that is wrong shifts the first strobe away from the PER-th cycle, or changes the spacing of later strobes, within one period. A faulty flag or state register shows on wake_irq, xcvr_rst or evt_out at the very next edge.

// File: rtl/esc_pkg.sv
package esc_pkg;

    localparam int unsigned SEL_W    = 2;
    localparam int unsigned N_PRESET = 1 << SEL_W;

    typedef enum logic [1:0] {
        PW_ACTIVE = 2'd0,
        PW_SLEEP  = 2'd1,
        PW_OFF    = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic             force_off;
        logic             sleep_en;
        logic             beacon_en;
        logic [SEL_W-1:0] beacon_sel;
        logic             one_pulse;
        logic [SEL_W-1:0] win_sel;
    } port_cfg_t;

    typedef struct packed {
        logic pwr_en;
        logic rst_pulse;
        logic beacon;
        logic awake;
        logic wake_irq;
    } port_out_t;

    // largest entry of a preset table, used to size counters
    function automatic int unsigned preset_max(input int unsigned tbl [N_PRESET]);
        int unsigned m;
        m = 0;
        for (int k = 0; k < int'(N_PRESET); k++) begin
            if (tbl[k] > m) m = tbl[k];
        end
        return m;
    endfunction

endpackage

// File: rtl/esc_beacon.sv
module esc_beacon
    import esc_pkg::*;
#(
    parameter int unsigned PER [N_PRESET] = '{16, 32, 64, 128}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             strobe
);

    localparam int unsigned CW = $clog2(preset_max(PER) + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        last   = CW'(PER[sel] - 1);
        strobe = run && (cnt == last);
    end

    // count sleeping cycles, restart after each strobe
    always_ff @(posedge clk) begin
        if (rst || !run || strobe) cnt <= '0;
        else                       cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/esc_pair_qual.sv
module esc_pair_qual
    import esc_pkg::*;
#(
    parameter int unsigned WIN [N_PRESET] = '{8, 16, 32, 64}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             listen,
    input  logic             one_pulse,
    input  logic [SEL_W-1:0] sel,
    input  logic             pulse,
    output logic             hit
);

    localparam int unsigned CW = $clog2(preset_max(WIN) + 1);

    logic          armed;
    logic [CW-1:0] wcnt;
    logic [CW-1:0] wlast;

    always_comb begin
        wlast = CW'(WIN[sel] - 1);
        hit   = listen && pulse && (one_pulse || armed);
    end

    always_ff @(posedge clk) begin
        if (rst || !listen || one_pulse) begin
            armed <= 1'b0;
            wcnt  <= '0;
        end else if (!armed) begin
            if (pulse) begin
                armed <= 1'b1;
                wcnt  <= '0;
            end
        end else if (!pulse) begin
            if (wcnt == wlast) begin
                armed <= 1'b0;
                wcnt  <= '0;
            end else begin
                wcnt  <= wcnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/esc_port.sv
module esc_port
    import esc_pkg::*;
#(
    parameter int unsigned QUIET_CYC             = 4,
    parameter int unsigned BEACON_PER [N_PRESET] = '{16, 32, 64, 128},
    parameter int unsigned PAIR_WIN   [N_PRESET] = '{8, 16, 32, 64}
) (
    input  logic      clk,
    input  logic      rst,
    input  port_cfg_t cfg,
    input  logic      line_energy,
    input  logic      rx_pulse,
    input  logic      irq_clr,
    output port_out_t po
);

    localparam int unsigned QW = $clog2(QUIET_CYC + 1);

    pwr_state_e    state, nxt;
    logic [QW-1:0] qcnt;
    logic          quiet_done;
    logic          asleep;
    logic          pair_hit;
    logic          woke;
    logic          rst_set;
    logic          rst_q;
    logic          irq_q;

    assign asleep     = (state == PW_SLEEP);
    assign quiet_done = cfg.sleep_en && !line_energy && (qcnt == QW'(QUIET_CYC - 1));

    esc_beacon #(.PER(BEACON_PER)) u_bcn (
        .clk    (clk),
        .rst    (rst),
        .run    (asleep && cfg.beacon_en),
        .sel    (cfg.beacon_sel),
        .strobe (po.beacon)
    );

    esc_pair_qual #(.WIN(PAIR_WIN)) u_pair (
        .clk       (clk),
        .rst       (rst),
        .listen    (asleep),
        .one_pulse (cfg.one_pulse),
        .sel       (cfg.win_sel),
        .pulse     (rx_pulse),
        .hit       (pair_hit)
    );

    always_comb begin
        nxt     = state;
        woke    = 1'b0;
        rst_set = 1'b0;
        unique case (state)
            PW_OFF: begin
                if (!cfg.force_off) begin
                    nxt     = PW_ACTIVE;
                    rst_set = 1'b1;
                end
            end
            PW_ACTIVE: begin
                if (cfg.force_off)  nxt = PW_OFF;
                else if (quiet_done) nxt = PW_SLEEP;
            end
            PW_SLEEP: begin
                if (cfg.force_off) begin
                    nxt = PW_OFF;
                end else if (!cfg.sleep_en) begin
                    nxt = PW_ACTIVE;
                end else if (line_energy || pair_hit) begin
                    nxt  = PW_ACTIVE;
                    woke = 1'b1;
                end
            end
            default: nxt = PW_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PW_ACTIVE;
            rst_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            state <= nxt;
            rst_q <= rst_set;
            if (woke)         irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    // consecutive quiet cycles while powered with sleep allowed
    always_ff @(posedge clk) begin
        if (rst || state != PW_ACTIVE || !cfg.sleep_en || line_energy || quiet_done)
            qcnt <= '0;
        else
            qcnt <= qcnt + QW'(1);
    end

    assign po.pwr_en    = (state == PW_ACTIVE);
    assign po.awake     = !asleep;
    assign po.rst_pulse = rst_q;
    assign po.wake_irq  = irq_q;

endmodule

// File: rtl/energy_sleep_ctrl.sv
module energy_sleep_ctrl
    import esc_pkg::*;
#(
    parameter int unsigned NPORTS                = 2,
    parameter int unsigned QUIET_CYC             = 4,
    parameter int unsigned BEACON_PER [N_PRESET] = '{16, 32, 64, 128},
    parameter int unsigned PAIR_WIN   [N_PRESET] = '{8, 16, 32, 64}
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORTS-1:0]       force_off,
    input  logic [NPORTS-1:0]       sleep_en,
    input  logic [NPORTS-1:0]       beacon_en,
    input  logic [SEL_W*NPORTS-1:0] beacon_sel,
    input  logic [NPORTS-1:0]       one_pulse_wake,
    input  logic [SEL_W*NPORTS-1:0] pair_win_sel,
    input  logic [NPORTS-1:0]       line_energy,
    input  logic [NPORTS-1:0]       rx_pulse,
    input  logic [NPORTS-1:0]       irq_clr,
    input  logic [NPORTS-1:0]       evt_en,
    output logic [NPORTS-1:0]       xcvr_pwr_en,
    output logic [NPORTS-1:0]       xcvr_rst,
    output logic [NPORTS-1:0]       beacon,
    output logic [NPORTS-1:0]       awake,
    output logic [NPORTS-1:0]       wake_irq,
    output logic                    evt_out
);

    for (genvar i = 0; i < int'(NPORTS); i++) begin : g_port
        port_cfg_t cfg;
        port_out_t po;

        assign cfg.force_off  = force_off[i];
        assign cfg.sleep_en   = sleep_en[i];
        assign cfg.beacon_en  = beacon_en[i];
        assign cfg.beacon_sel = beacon_sel[SEL_W*i +: SEL_W];
        assign cfg.one_pulse  = one_pulse_wake[i];
        assign cfg.win_sel    = pair_win_sel[SEL_W*i +: SEL_W];

        esc_port #(
            .QUIET_CYC  (QUIET_CYC),
            .BEACON_PER (BEACON_PER),
            .PAIR_WIN   (PAIR_WIN)
        ) u_port (
            .clk         (clk),
            .rst         (rst),
            .cfg         (cfg),
            .line_energy (line_energy[i]),
            .rx_pulse    (rx_pulse[i]),
            .irq_clr     (irq_clr[i]),
            .po          (po)
        );

        assign xcvr_pwr_en[i] = po.pwr_en;
        assign xcvr_rst[i]    = po.rst_pulse;
        assign beacon[i]      = po.beacon;
        assign awake[i]       = po.awake;
        assign wake_irq[i]    = po.wake_irq;
    end

    assign evt_out = |(wake_irq & evt_en);

endmodule

// File: rtl/energy_sleep_chk.sv
module energy_sleep_chk #(
    parameter int unsigned NPORTS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NPORTS-1:0] force_off,
    input logic [NPORTS-1:0] sleep_en,
    input logic [NPORTS-1:0] beacon_en,
    input logic [NPORTS-1:0] irq_clr,
    input logic [NPORTS-1:0] evt_en,
    input logic [NPORTS-1:0] xcvr_pwr_en,
    input logic [NPORTS-1:0] xcvr_rst,
    input logic [NPORTS-1:0] beacon,
    input logic [NPORTS-1:0] awake,
    input logic [NPORTS-1:0] wake_irq,
    input logic              evt_out
);

    for (genvar i = 0; i < int'(NPORTS); i++) begin : g_chk
        p_off_hold_r1: assert property (@(posedge clk) disable iff (rst)
            force_off[i] |=> !xcvr_pwr_en[i]);

        p_rst_powered_r2: assert property (@(posedge clk) disable iff (rst)
            xcvr_rst[i] |-> xcvr_pwr_en[i]);

        p_rst_single_r2: assert property (@(posedge clk) disable iff (rst)
            xcvr_rst[i] |=> !xcvr_rst[i]);

        p_wake_flag_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(awake[i]) && xcvr_pwr_en[i] && $past(sleep_en[i]) |-> wake_irq[i]);

        p_stay_on_r5: assert property (@(posedge clk) disable iff (rst)
            $past(!sleep_en[i] && !force_off[i]) |-> xcvr_pwr_en[i]);

        p_beacon_asleep_r8: assert property (@(posedge clk) disable iff (rst)
            beacon[i] |-> !xcvr_pwr_en[i] && !awake[i] && beacon_en[i]);

        p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            wake_irq[i] && !irq_clr[i] |=> wake_irq[i]);
    end

    p_evt_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_en == '0) |-> !evt_out);

endmodule

bind energy_sleep_ctrl energy_sleep_chk #(.NPORTS(NPORTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .force_off   (force_off),
    .sleep_en    (sleep_en),
    .beacon_en   (beacon_en),
    .irq_clr     (irq_clr),
    .evt_en      (evt_en),
    .xcvr_pwr_en (xcvr_pwr_en),
    .xcvr_rst    (xcvr_rst),
    .beacon      (beacon),
    .awake       (awake),
    .wake_irq    (wake_irq),
    .evt_out     (evt_out)
);

// File: tb/sim_energy_sleep_ctrl.sv
module sim_energy_sleep_ctrl;

    localparam int NP    = 2;
    localparam int QUIET = 4;
    localparam int NVEC  = 23;

    // {force_off, sleep_en, line_energy, exp pwr_en, exp xcvr_rst, exp wake_irq} for port 0
    localparam logic [5:0] VEC [NVEC] = '{
        6'b000_100, 6'b100_000, 6'b100_000, 6'b000_110, 6'b000_100,
        6'b010_100, 6'b010_100, 6'b011_100, 6'b010_100, 6'b010_100,
        6'b010_100, 6'b010_000, 6'b010_000, 6'b011_101, 6'b000_101,
        6'b000_101, 6'b010_101, 6'b010_101, 6'b010_101, 6'b010_001,
        6'b110_001, 6'b010_111, 6'b010_101
    };

    logic            clk = 1'b0;
    logic            rst;
    logic [NP-1:0]   force_off, sleep_en, beacon_en, one_pulse_wake;
    logic [NP-1:0]   line_energy, rx_pulse, irq_clr, evt_en;
    logic [2*NP-1:0] beacon_sel, pair_win_sel;
    logic [NP-1:0]   xcvr_pwr_en, xcvr_rst, beacon, awake, wake_irq;
    logic            evt_out;

    int nchk = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    energy_sleep_ctrl #(
        .NPORTS     (NP),
        .QUIET_CYC  (QUIET),
        .BEACON_PER ('{16, 32, 64, 128}),
        .PAIR_WIN   ('{8, 16, 32, 64})
    ) u0 (
        .clk(clk), .rst(rst), .force_off(force_off), .sleep_en(sleep_en),
        .beacon_en(beacon_en), .beacon_sel(beacon_sel), .one_pulse_wake(one_pulse_wake),
        .pair_win_sel(pair_win_sel), .line_energy(line_energy), .rx_pulse(rx_pulse),
        .irq_clr(irq_clr), .evt_en(evt_en), .xcvr_pwr_en(xcvr_pwr_en),
        .xcvr_rst(xcvr_rst), .beacon(beacon), .awake(awake), .wake_irq(wake_irq),
        .evt_out(evt_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic go_sleep(input int p);
        sleep_en[p]    = 1'b1;
        line_energy[p] = 1'b0;
        repeat (QUIET + 1) tick();
        chk("R3 quiet entry pwr_en", xcvr_pwr_en[p], 0);
        chk("R3 quiet entry awake", awake[p], 0);
    endtask

    task automatic pulse(input int p);
        rx_pulse[p] = 1'b1;
        tick();
        rx_pulse[p] = 1'b0;
    endtask

    task automatic clear_irq(input int p);
        irq_clr[p] = 1'b1;
        tick();
        irq_clr[p] = 1'b0;
    endtask

    task automatic count_beacons(input int n, input int per,
                                 output int hits, output int first, output int badgap);
        int prev;
        hits = 0; first = -1; badgap = 0; prev = -1;
        for (int j = 1; j <= n; j++) begin
            tick();
            if (beacon[0]) begin
                if (first < 0) first = j;
                else if (j - prev != per) badgap++;
                prev = j;
                hits++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        int h, f, g;
        rst = 1'b1;
        force_off = '0; sleep_en = '0; beacon_en = '0; one_pulse_wake = '0;
        line_energy = '0; rx_pulse = '0; irq_clr = '0; evt_en = '0;
        beacon_sel = '0; pair_win_sel = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R5 reset pwr_en", xcvr_pwr_en, 3);
        chk("R2 reset xcvr_rst", xcvr_rst, 0);
        chk("R9 reset wake_irq", wake_irq, 0);
        chk("R10 reset evt_out", evt_out, 0);

        for (int k = 0; k < NVEC; k++) begin
            force_off[0]   = VEC[k][5];
            sleep_en[0]    = VEC[k][4];
            line_energy[0] = VEC[k][3];
            tick();
            chk("R1 R2 R3 R4 R5 vector", {xcvr_pwr_en[0], xcvr_rst[0], wake_irq[0]}, int'(VEC[k][2:0]));
            chk("R10 port1 untouched", xcvr_pwr_en[1], 1);
        end

        // R9: clear in the same cycle as a wake
        go_sleep(0);
        line_energy[0] = 1'b1; irq_clr[0] = 1'b1;
        tick();
        chk("R9 clear with wake keeps flag", wake_irq[0], 1);
        chk("R4 energy wake pwr_en", xcvr_pwr_en[0], 1);
        chk("R4 energy wake no reset", xcvr_rst[0], 0);
        chk("R4 awake", awake[0], 1);
        tick();
        chk("R9 clear alone", wake_irq[0], 0);
        irq_clr[0] = 1'b0;
        tick();
        chk("R9 stays clear", wake_irq[0], 0);

        // R6: single pulse wake
        one_pulse_wake[0] = 1'b1;
        go_sleep(0);
        pulse(0);
        chk("R6 single pulse wakes", xcvr_pwr_en[0], 1);
        chk("R6 wake flag", wake_irq[0], 1);
        clear_irq(0);

        // R7: second pulse exactly at window end, select 0 -> 8
        one_pulse_wake[0] = 1'b0;
        pair_win_sel[1:0] = 2'd0;
        go_sleep(0);
        pulse(0);
        repeat (7) tick();
        chk("R7 one pulse does not wake", xcvr_pwr_en[0], 0);
        pulse(0);
        chk("R7 second pulse at window edge", xcvr_pwr_en[0], 1);
        clear_irq(0);

        // R7: late second pulse, select 1 -> 16
        pair_win_sel[1:0] = 2'd1;
        go_sleep(0);
        pulse(0);
        repeat (16) tick();
        pulse(0);
        chk("R7 late pulse ignored", xcvr_pwr_en[0], 0);
        pulse(0);
        chk("R7 rearmed pair wakes", xcvr_pwr_en[0], 1);
        clear_irq(0);

        // R8: beacon strobes
        go_sleep(0);
        count_beacons(20, 16, h, f, g);
        chk("R8 no beacon when disabled", h, 0);
        beacon_sel[1:0] = 2'd0;
        beacon_en[0] = 1'b1;
        count_beacons(48, 16, h, f, g);
        chk("R8 sel0 strobe count", h, 3);
        chk("R8 sel0 first strobe", f, 15);
        chk("R8 sel0 spacing", g, 0);
        beacon_en[0] = 1'b0;
        tick();
        beacon_sel[1:0] = 2'd1;
        beacon_en[0] = 1'b1;
        count_beacons(70, 32, h, f, g);
        chk("R8 sel1 strobe count", h, 2);
        chk("R8 sel1 first strobe", f, 31);
        chk("R8 sel1 spacing", g, 0);
        line_energy[0] = 1'b1;
        tick();
        chk("R4 wake during beacon", xcvr_pwr_en[0], 1);
        count_beacons(20, 16, h, f, g);
        chk("R8 no beacon while powered", h, 0);

        // R10: event gating and independence
        evt_en = 2'b00; tick();
        chk("R10 no enables", evt_out, 0);
        evt_en = 2'b10; tick();
        chk("R10 other port enable", evt_out, 0);
        evt_en = 2'b01; tick();
        chk("R10 own enable", evt_out, 1);
        go_sleep(1);
        chk("R10 port0 unaffected", xcvr_pwr_en[0], 1);
        line_energy[1] = 1'b1;
        tick();
        chk("R4 port1 wake", xcvr_pwr_en[1], 1);
        chk("R4 port1 flag", wake_irq[1], 1);
        clear_irq(0);
        chk("R9 port0 cleared", wake_irq[0], 0);
        chk("R10 port1 flag kept", wake_irq[1], 1);
        chk("R10 port1 masked", evt_out, 0);
        evt_en = 2'b10; tick();
        chk("R10 port1 enabled", evt_out, 1);
        sleep_en[1] = 1'b0;

        // R5: dropping sleep enable while asleep
        beacon_en[0] = 1'b0;
        go_sleep(0);
        sleep_en[0] = 1'b0;
        tick();
        chk("R5 disable wakes", xcvr_pwr_en[0], 1);
        chk("R5 no flag on disable", wake_irq[0], 0);
        repeat (10) tick();
        chk("R5 stays powered", xcvr_pwr_en[0], 1);

        // R1 and R2: forced off ignores activity
        force_off[0] = 1'b1;
        for (int j = 0; j < 10; j++) begin
            line_energy[0] = j[0];
            rx_pulse[0]    = j[1];
            tick();
            chk("R1 forced off", xcvr_pwr_en[0], 0);
        end
        force_off[0] = 1'b0; rx_pulse[0] = 1'b0;
        tick();
        chk("R2 release powers", xcvr_pwr_en[0], 1);
        chk("R2 reset pulse", xcvr_rst[0], 1);
        tick();
        chk("R2 pulse one cycle", xcvr_rst[0], 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule